// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector

This block compares a reference square wave with the square wave fed back from a controlled oscillator. Its output is a three-position command for an external charge pump: source current, sink current or high impedance. Both inputs are taken as asynchronous to the fast system clock. Each input passes through a synchroniser and then a rising-edge detector. From that point on, only leading edges matter, so the duty cycle of either input has no effect on the command.

A reference edge sets an "up" state. A feedback edge sets a "down" state. When both states are set, the block clears them together on the next system clock. If the frequencies differ for a sustained time, the pulses fall consistently on one side, and this slews the loop toward the correct frequency. The usable linear phase range spans 4π, because the memory states allow one of two conditions at start-up. A synchronous reset makes that start-up condition deterministic. A debug counter reports the length of each active pulse in system clocks.

The detector suits periodic clocks only. With NRZ data on the reference input, missing transitions make it command a falsely low frequency, so that use is not supported.

Top module: `pfd_tristate`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `up_o`, `dn_o`, `width_vld_o`, `width_o` and the synchroniser stages, and `pump_o` reads 2'b00.
- R2: A rising edge on `ref_in` sets `up_o`. The input is first seen high at clock edge n, and `up_o` is high after edge n+2, the third edge to sample it high.
- R3: A rising edge on `fb_in` sets `dn_o`, with the same three-edge latency as R2.
- R4: When `up_o` and `dn_o` are both high, both are low after the next clock edge, so the overlap lasts exactly one cycle. The exception is a new rising edge detected in that same cycle, which sets its state again.
- R5: Falling edges, input high time and repeated high levels have no effect: the state set by an edge holds until the R4 clear, whatever the input does after that edge.
- R6: `pump_o` encodes the command as follows: 2'b01 when only up is set (source), 2'b10 when only down is set (sink), and 2'b00 otherwise (high impedance, including during the overlap cycle).
- R7: `pump_o` never shows 2'b11.
- R8: With a reference faster than the feedback, once the loop has passed the first edges `pump_o` produces only source commands and no sink commands.
- R9: An active interval is a run of cycles with `up_o` or `dn_o` high. When it ends, `width_o` takes the number of cycles in the run, and `width_vld_o` is high for one cycle. Both take effect one clock edge after the outputs fall.
- R10: The width count saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Feedback oscillator square wave, asynchronous |
| up_o | output | 1 | Up state (source request) |
| dn_o | output | 1 | Down state (sink request) |
| pump_o | output | 2 | Encoded pump command: 00 high-Z, 01 source, 10 sink |
| width_o | output | CNT_W | Length of the last active pulse in clocks |
| width_vld_o | output | 1 | One-cycle strobe when width_o updates |

## Verification
Two cases are hard to reach from the ports. The first is the one-cycle overlap followed by a fresh edge that lands in the clearing cycle itself. The second is a pulse long enough to saturate the width counter. The random stimulus runs two independent square waves. Their half-periods are redrawn often, down to a single clock, so edges frequently coincide with the overlap cycle. Directed runs then hold the feedback silent while the reference keeps toggling, which pushes the counter to saturation. Further directed runs pair short and long reference high times at a fixed edge spacing, to show that the pulse width does not depend on duty cycle.

// File: rtl/pfd_tristate.sv
`timescale 1ns/1ps
module pfd_tristate #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_in,
  input  logic             fb_in,
  output logic             up_o,
  output logic             dn_o,
  output logic [1:0]       pump_o,
  output logic [CNT_W-1:0] width_o,
  output logic             width_vld_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // [SYNC_STAGES-1] is the synchronised level, [SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] ref_sh, fb_sh;
  logic                 ref_rise, fb_rise;
  logic                 up_q, dn_q, both, act;
  logic [CNT_W-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sh <= '0;
      fb_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[SYNC_STAGES-1:0], ref_in};
      fb_sh  <= {fb_sh[SYNC_STAGES-1:0], fb_in};
    end
  end

  assign ref_rise = ref_sh[SYNC_STAGES-1] & ~ref_sh[SYNC_STAGES];
  assign fb_rise  = fb_sh[SYNC_STAGES-1]  & ~fb_sh[SYNC_STAGES];
  assign both     = up_q & dn_q;
  assign act      = up_q | dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= ref_rise | (up_q & ~both);
      dn_q <= fb_rise  | (dn_q & ~both);
    end
  end

  assign up_o   = up_q;
  assign dn_o   = dn_q;
  assign pump_o = {dn_q & ~up_q, up_q & ~dn_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      width_o     <= '0;
      width_vld_o <= 1'b0;
    end else begin
      if (act)
        cnt <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      else
        cnt <= '0;
      width_vld_o <= !act && (cnt != '0);
      if (!act && (cnt != '0))
        width_o <= cnt;
    end
  end

  // R2
  up_set_chk: assert property (@(posedge clk) disable iff (rst) ref_rise |=> up_q);
  // R3
  dn_set_chk: assert property (@(posedge clk) disable iff (rst) fb_rise |=> dn_q);
  // R4
  overlap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (both && !ref_rise && !fb_rise) |=> (!up_q && !dn_q));
  // R7
  pump_code_chk: assert property (@(posedge clk) disable iff (rst) pump_o != 2'b11);
  // R9
  vld_single_chk: assert property (@(posedge clk) disable iff (rst) width_vld_o |=> !width_vld_o);
  // R10
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (act && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: tb/sim_pfd_tristate.sv
`timescale 1ns/1ps
module sim_pfd_tristate;
  localparam int CW   = 5;
  localparam int MAXW = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic up_o, dn_o, width_vld_o;
  logic [1:0] pump_o;
  logic [CW-1:0] width_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pfd_tristate #(.SYNC_STAGES(2), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .up_o(up_o), .dn_o(dn_o), .pump_o(pump_o),
    .width_o(width_o), .width_vld_o(width_vld_o));

  // requirement model: 3-edge latency, overlap clear, width counting
  logic [2:0] m_r, m_f;
  logic m_up, m_dn, m_vld;
  int m_cnt, m_w;

  always @(posedge clk) begin
    logic rr, fr, bo, ac;
    if (rst) begin
      m_r = '0; m_f = '0; m_up = 0; m_dn = 0; m_vld = 0; m_cnt = 0; m_w = 0;
    end else begin
      rr = m_r[1] & ~m_r[2];
      fr = m_f[1] & ~m_f[2];
      bo = m_up & m_dn;
      ac = m_up | m_dn;
      m_vld = !ac && m_cnt != 0;
      if (m_vld) m_w = m_cnt;
      m_cnt = ac ? ((m_cnt == MAXW) ? MAXW : m_cnt + 1) : 0;
      m_up = rr | (m_up & ~bo);
      m_dn = fr | (m_dn & ~bo);
      m_r = {m_r[1:0], ref_in};
      m_f = {m_f[1:0], fb_in};
    end
  end

  function automatic logic [1:0] exp_pump(input logic u, input logic d);
    return {d & ~u, u & ~d};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(up_o == m_up, "R2 up state", int'(up_o), int'(m_up));
    chk(dn_o == m_dn, "R3 down state", int'(dn_o), int'(m_dn));
    chk(pump_o == exp_pump(m_up, m_dn), "R6 pump code", int'(pump_o), int'(exp_pump(m_up, m_dn)));
    chk(pump_o != 2'b11, "R7 no 11 code", int'(pump_o), 0);
    chk(width_vld_o == m_vld, "R9 width strobe", int'(width_vld_o), int'(m_vld));
    if (m_vld) chk(int'(width_o) == m_w, "R9 width value", int'(width_o), m_w);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; idle(3); rst = 1'b0;
  endtask

  // ref rises, held for hold cycles, fb rises gap cycles after ref; returns strobed width
  task automatic pair(input int hold, input int gap, output int w);
    w = -1;
    ref_in = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (i == hold) ref_in = 1'b0;
      if (i == gap) fb_in = 1'b1;
      step();
      if (width_vld_o) w = int'(width_o);
    end
    ref_in = 1'b0; fb_in = 1'b0;
    idle(6);
  endtask

  initial begin
    int w1, w2, rh, fh, rc, fc, nup, ndn, both_cnt;
    void'($urandom(32'd2024));
    @(negedge clk);
    // R1: reset with inputs high
    ref_in = 1'b1; fb_in = 1'b1;
    idle(4);
    chk(up_o == 0 && dn_o == 0, "R1 states in reset", int'({up_o, dn_o}), 0);
    chk(pump_o == 2'b00 && !width_vld_o && width_o == 0, "R1 pump/width in reset", int'(pump_o), 0);
    ref_in = 1'b0; fb_in = 1'b0;
    rst = 1'b0;
    idle(5);

    // R2 latency
    ref_in = 1'b1;
    step(); step();
    chk(up_o == 0, "R2 not before third edge", int'(up_o), 0);
    step();
    chk(up_o == 1, "R2 set on third edge", int'(up_o), 1);
    // R5: falling edge leaves up set
    ref_in = 1'b0; idle(5);
    chk(up_o == 1, "R5 fall ignored", int'(up_o), 1);
    // R3 and R4
    fb_in = 1'b1;
    step(); step();
    chk(dn_o == 0, "R3 not before third edge", int'(dn_o), 0);
    step();
    chk(dn_o == 1 && up_o == 1, "R4 overlap cycle", int'({up_o, dn_o}), 3);
    chk(pump_o == 2'b00, "R6 overlap is high-Z", int'(pump_o), 0);
    step();
    chk(up_o == 0 && dn_o == 0, "R4 both cleared", int'({up_o, dn_o}), 0);
    step();
    chk(width_vld_o == 1 && int'(width_o) == 9, "R9 width after ref-first pulse", int'(width_o), 9);
    fb_in = 1'b0; idle(5);

    // R4: simultaneous edges give exactly one overlap cycle
    ref_in = 1'b1; fb_in = 1'b1; both_cnt = 0;
    for (int i = 0; i < 8; i++) begin step(); if (up_o && dn_o) both_cnt++; end
    chk(both_cnt == 1, "R4 single overlap", both_cnt, 1);
    ref_in = 1'b0; fb_in = 1'b0; idle(5);

    // R5: duty cycle independence
    pair(2, 8, w1);
    pair(40, 8, w2);
    chk(w1 == w2 && w1 == 9, "R5 width independent of high time", w2, w1);

    // R10: saturation with fb silent
    ref_in = 1'b1; idle(3);
    for (int i = 0; i < 25; i++) begin ref_in = ~ref_in; step(); end
    ref_in = 1'b0; idle(20);
    chk(up_o == 1, "R5 repeated ref edges keep up", int'(up_o), 1);
    fb_in = 1'b1; idle(6);
    chk(int'(width_o) == MAXW, "R10 width saturates", int'(width_o), MAXW);
    fb_in = 1'b0; idle(5);

    // R8: ref faster than fb
    do_reset();
    nup = 0; ndn = 0; rc = 0; fc = 0;
    for (int i = 0; i < 800; i++) begin
      if (rc == 0) begin ref_in = ~ref_in; rc = 5; end
      if (fc == 0) begin fb_in = ~fb_in; fc = 7; end
      rc--; fc--;
      step();
      if (i >= 100) begin
        if (pump_o == 2'b01) nup++;
        if (pump_o == 2'b10) ndn++;
      end
    end
    chk(nup > 0, "R8 source pulses present", nup, 1);
    chk(ndn == 0, "R8 no sink pulses", ndn, 0);

    // random square waves
    ref_in = 0; fb_in = 0; do_reset();
    rh = 3; fh = 4; rc = 0; fc = 0;
    for (int i = 0; i < 40000; i++) begin
      if (i % 1500 == 0) begin rh = 1 + int'($urandom % 12); fh = 1 + int'($urandom % 12); end
      if (rc == 0) begin ref_in = ~ref_in; rc = rh; end
      if (fc == 0) begin fb_in = ~fb_in; fc = fh; end
      rc--; fc--;
      if (i % 9000 == 8999) begin fb_in = 0; for (int k = 0; k < 50; k++) begin ref_in = ~ref_in; step(); end end
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule